// File: doc/BRIEF.md
# Enabled-Channel Sample Packer with Sync Realignment

The block receives one complex sample from each of four channels on every valid input cycle. It keeps only the samples of the channels whose enable bit is set and writes them, lowest channel first, into a continuous stream of 32-bit slots. Each time four slots fill up, one 128-bit word leaves the block with a one-cycle valid. With all four channels enabled a word leaves on every valid input cycle. With fewer channels enabled, words leave less often, and a downstream store of fixed size therefore holds more time samples per channel.

A sync pulse restarts the packing phase. Any partly filled word is dropped, and the sample that arrives in the sync cycle goes into slot 0. A capture that starts on a trigger therefore always begins at a word boundary, with no shift of zero to three samples. The enable mask is taken in on the sync cycle, or on the first clock edge after reset. A change to the mask at any other time waits for the next sync.

Top module: `chan_packer`

## Requirements
- R1: While reset is asserted, out_valid is 0 and out_data is all zeros.
- R2: With exactly one channel enabled, each output word holds four consecutive samples of that channel, oldest in slot 0. One word is produced for every four valid input cycles.
- R3: With two channels enabled, each word holds two time steps. Within a step the lower-numbered channel comes first, so the slot order is lo(t), hi(t), lo(t+1), hi(t+1). A word is produced on every second valid input cycle.
- R4: With all four channels enabled, every valid input cycle produces one word with channel c in slot c. A word appears on out_valid one clock after the input cycle that completes it.
- R5: With three channels enabled, slots fill as a continuous stream, and a time step's samples may be split across two consecutive words.
- R6: Samples of disabled channels never appear in any output word. With no channel enabled, no word is produced.
- R7: Input lane c occupies in_data bits [32c+31:32c], and output slot k occupies out_data bits [32k+31:32k]. Within each 32-bit sample, I is in the low 16 bits and Q in the high 16 bits, and both pass through unchanged.
- R8: A sync pulse discards any partly filled word. A valid sample in the sync cycle is placed from slot 0. A sync with in_valid low only clears the packing state.
- R9: The enable mask is captured on a sync cycle and on the first clock edge after reset is released. A change to chan_en at any other time has no effect until then.
- R10: A cycle with in_valid low and no sync changes no packing state and produces no word. out_data holds its last value whenever out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | All four input lanes carry a sample this cycle |
| in_data | input | 128 | Four lanes of 32-bit samples; lane c at bits 32c and up, I low and Q high |
| chan_en | input | 4 | Channel enable mask; bit c enables lane c |
| sync | input | 1 | Restart the packing phase and capture chan_en |
| out_valid | output | 1 | out_data holds a newly completed word (one-cycle pulse) |
| out_data | output | 128 | Packed word; slot k at bits 32k and up |

## Verification
A wrong slot pointer shows at the ports on the very next completed word. The samples come out rotated, the word arrives a cycle early or late against the expected cadence, or words straddle a sync boundary. A stale enable mask or stale held slots show up as samples from a disabled channel, or from before the sync, within the first word after the fault. The scoreboard compares every word against a slot queue built from the requirements and checks the clock in which it must appear. A word that is missing or extra is therefore reported within one cycle of its expected time.

// File: rtl/chan_packer_pkg.sv
package chan_packer_pkg;
  localparam int unsigned IQ_W   = 16;
  localparam int unsigned SAMP_W = 2 * IQ_W;
  typedef logic [SAMP_W-1:0] samp_t;
endpackage

// File: rtl/pk_mask_ctl.sv
// Holds the active channel mask; a new mask is taken on sync or on the
// first edge after reset release.
module pk_mask_ctl #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic [NUM_CH-1:0] eff_en_o
);
  logic              armed_q, armed_d;
  logic [NUM_CH-1:0] mask_q, mask_d;
  logic              load_en;

  always_comb begin
    load_en  = sync_i || !armed_q;
    eff_en_o = load_en ? en_i : mask_q;
    armed_d  = 1'b1;
    mask_d   = load_en ? en_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      armed_q <= armed_d;
      if (load_en) mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/pk_compact.sv
// Squeezes the enabled lanes into a dense list, lowest channel first.
module pk_compact
  import chan_packer_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = $clog2(NUM_CH + 1)
) (
  input  logic [NUM_CH*SAMP_W-1:0] lane_i,
  input  logic [NUM_CH-1:0]        en_i,
  output logic [NUM_CH*SAMP_W-1:0] list_o,
  output logic [CNT_W-1:0]         cnt_o
);
  int idx;

  always_comb begin
    list_o = '0;
    idx    = 0;
    for (int c = 0; c < int'(NUM_CH); c++) begin
      if (en_i[c]) begin
        list_o[idx*SAMP_W +: SAMP_W] = lane_i[c*SAMP_W +: SAMP_W];
        idx = idx + 1;
      end
    end
    cnt_o = CNT_W'(idx);
  end
endmodule

// File: rtl/pk_slot_merge.sv
// Appends a compacted list at the slot pointer; emits a full word when
// the slots wrap and carries the spill into the next word.
module pk_slot_merge
  import chan_packer_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = $clog2(NUM_CH + 1),
  parameter int unsigned PTR_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH*SAMP_W-1:0] hold_i,
  input  logic [PTR_W-1:0]         ptr_i,
  input  logic [NUM_CH*SAMP_W-1:0] list_i,
  input  logic [CNT_W-1:0]         cnt_i,
  output logic [NUM_CH*SAMP_W-1:0] word_o,
  output logic                     emit_o,
  output logic [NUM_CH*SAMP_W-1:0] hold_o,
  output logic [PTR_W-1:0]         ptr_o
);
  localparam int unsigned WORD_W = NUM_CH * SAMP_W;

  logic [2*WORD_W-1:0] ext;
  int                  total;

  always_comb begin
    ext = {{WORD_W{1'b0}}, hold_i};
    for (int j = 0; j < int'(NUM_CH); j++) begin
      if (j < int'(cnt_i))
        ext[(int'(ptr_i) + j)*SAMP_W +: SAMP_W] = list_i[j*SAMP_W +: SAMP_W];
    end
    total  = int'(ptr_i) + int'(cnt_i);
    emit_o = (total >= int'(NUM_CH));
    word_o = ext[WORD_W-1:0];
    if (emit_o) begin
      hold_o = ext[2*WORD_W-1:WORD_W];
      ptr_o  = PTR_W'(total - int'(NUM_CH));
    end else begin
      hold_o = ext[WORD_W-1:0];
      ptr_o  = PTR_W'(total);
    end
  end
endmodule

// File: rtl/chan_packer.sv
module chan_packer
  import chan_packer_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [NUM_CH*SAMP_W-1:0] in_data,
  input  logic [NUM_CH-1:0]        chan_en,
  input  logic                     sync,
  output logic                     out_valid,
  output logic [NUM_CH*SAMP_W-1:0] out_data
);
  localparam int unsigned WORD_W = NUM_CH * SAMP_W;
  localparam int unsigned CNT_W  = $clog2(NUM_CH + 1);
  localparam int unsigned PTR_W  = $clog2(NUM_CH);

  logic [NUM_CH-1:0] eff_en;
  logic [WORD_W-1:0] list;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] hold_q, hold_d, hold_base, m_hold, m_word;
  logic [PTR_W-1:0]  ptr_q, ptr_d, ptr_base, m_ptr;
  logic              m_emit;
  logic              ov_d;
  logic [WORD_W-1:0] od_d;
  logic              st_en;

  pk_mask_ctl #(.NUM_CH(NUM_CH)) u_mask (
    .clk(clk), .rst_n(rst_n), .sync_i(sync), .en_i(chan_en), .eff_en_o(eff_en)
  );

  pk_compact #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_compact (
    .lane_i(in_data), .en_i(eff_en), .list_o(list), .cnt_o(cnt)
  );

  // A sync drops whatever partial word is held.
  always_comb begin
    ptr_base  = sync ? '0 : ptr_q;
    hold_base = sync ? '0 : hold_q;
  end

  pk_slot_merge #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_merge (
    .hold_i(hold_base), .ptr_i(ptr_base), .list_i(list), .cnt_i(cnt),
    .word_o(m_word), .emit_o(m_emit), .hold_o(m_hold), .ptr_o(m_ptr)
  );

  always_comb begin
    st_en = in_valid || sync;
    if (in_valid) begin
      ptr_d  = m_ptr;
      hold_d = m_hold;
    end else begin
      ptr_d  = ptr_base;
      hold_d = hold_base;
    end
    ov_d = in_valid && m_emit;
    od_d = ov_d ? m_word : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      hold_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (st_en) begin
        ptr_q  <= ptr_d;
        hold_q <= hold_d;
      end
      out_valid <= ov_d;
      if (ov_d) out_data <= od_d;
    end
  end
endmodule

// File: rtl/chan_packer_chk.sv
module chan_packer_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned WORD_W = NUM_CH * 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_data,
  input logic [NUM_CH-1:0] chan_en,
  input logic              sync,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_data
);
  assert_full_mask_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && in_valid && chan_en == '1) |=> (out_valid && out_data == $past(in_data)));

  assert_idle_no_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_data_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  assert_sync_single_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && in_valid && $countones(chan_en) == 1) |=> !out_valid);

  assert_sync_pair_partial_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && in_valid && $countones(chan_en) == 2) |=> !out_valid);

  assert_empty_mask_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && chan_en == '0) |=> !out_valid);
endmodule

bind chan_packer chan_packer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .chan_en(chan_en), .sync(sync), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_chan_packer.sv
`timescale 1ns/1ps
module test_chan_packer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_data;
  logic [3:0]   chan_en;
  logic         sync;
  logic         out_valid;
  logic [127:0] out_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [31:0]  sq[$];
  logic [127:0] exp_q[$];
  int           due_q[$];
  string        tag_q[$];
  logic [3:0]   m_mask;
  logic [127:0] last_data;

  always #5 clk = ~clk;

  chan_packer i_chan_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .chan_en(chan_en), .sync(sync), .out_valid(out_valid), .out_data(out_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] mk(int t);
    logic [127:0] d;
    for (int c = 0; c < 4; c++) begin
      logic [15:0] iv;
      iv = 16'(t * 16 + c + 1);
      d[c*32 +: 32] = {~iv, iv};
    end
    return d;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(bit v, bit sy, logic [3:0] en, logic [127:0] d, string tag);
    @(negedge clk);
    in_valid = v; sync = sy; chan_en = en; in_data = d;
    if (sy) begin sq.delete(); m_mask = en; end
    if (v) for (int c = 0; c < 4; c++) if (m_mask[c]) sq.push_back(d[c*32 +: 32]);
    while (sq.size() >= 4) begin
      exp_q.push_back({sq[3], sq[2], sq[1], sq[0]});
      due_q.push_back(cyc + 1);
      tag_q.push_back(tag);
      repeat (4) void'(sq.pop_front());
    end
  endtask

  task automatic do_reset(logic [3:0] en);
    @(negedge clk);
    rst_n = 0; in_valid = 0; sync = 0; chan_en = en; in_data = '0;
    sq.delete(); m_mask = en;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1", {127'b0, out_valid}, 128'b0);
    chk(out_data == '0, "R1", out_data, 128'b0);
    rst_n = 1;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      last_data = '0;
    end else if (out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected word", out_data, 128'b0);
      end else begin
        logic [127:0] e; int du; string tg;
        e = exp_q.pop_front(); du = due_q.pop_front(); tg = tag_q.pop_front();
        chk(out_data == e, {tg, " R7 data"}, out_data, e);
        chk(du == cyc, {tg, " R4 timing"}, 128'(cyc), 128'(du));
      end
      last_data = out_data;
    end else begin
      chk(out_data == last_data, "R10 hold", out_data, last_data);
      if (due_q.size() != 0 && due_q[0] < cyc) begin
        chk(1'b0, {tag_q[0], " missing word"}, 128'b0, exp_q[0]);
        void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    if (!done && cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int t = 0;
    do_reset(4'hF);
    // R4: all channels, captured at first edge after reset
    for (int i = 0; i < 5; i++) step(1, 0, 4'hF, mk(t++), "R4");
    // R9: mask change without sync is ignored
    for (int i = 0; i < 3; i++) step(1, 0, 4'h1, mk(t++), "R9");
    // R2: single channel, odd count leaves a partial word
    for (int i = 0; i < 9; i++) step(1, i == 0, 4'h2, mk(t++), "R2");
    // R3 + R10: two channels with idle gaps
    for (int i = 0; i < 6; i++) begin
      step(1, i == 0, 4'h5, mk(t++), "R3");
      step(0, 0, 4'h5, mk(999), "R10");
    end
    // R5: three channels spill across words
    for (int i = 0; i < 8; i++) step(1, i == 0, 4'hB, mk(t++), "R5");
    // R8: partial word dropped, sync sample lands in slot 0
    step(1, 1, 4'h3, mk(t++), "R8");
    step(1, 1, 4'h3, mk(t++), "R8");
    step(1, 0, 4'h3, mk(t++), "R8");
    step(1, 0, 4'h3, mk(t++), "R8");
    step(0, 1, 4'h3, mk(t++), "R8");
    step(1, 0, 4'h3, mk(t++), "R8");
    step(1, 0, 4'h3, mk(t++), "R8");
    // R6: empty mask yields nothing
    for (int i = 0; i < 5; i++) step(1, i == 0, 4'h0, mk(t++), "R6");
    // R7: explicit slot/IQ layout with channel 3 only
    step(1, 1, 4'h8, mk(50), "R7");
    step(1, 0, 4'h8, mk(51), "R7");
    step(1, 0, 4'h8, mk(52), "R7");
    step(1, 0, 4'h8, mk(53), "R7");
    step(0, 0, 4'h8, '0, "R7");
    chk(out_valid && out_data[15:0] == 16'(50*16+4) && out_data[31:16] == ~16'(50*16+4)
        && out_data[127:112] == ~16'(53*16+4),
        "R7 layout", out_data, {~16'(53*16+4), 80'b0, ~16'(50*16+4), 16'(50*16+4)});
    // R9: mask taken at reset release
    repeat (3) step(0, 0, 4'h8, '0, "R9");
    do_reset(4'h6);
    step(0, 0, 4'hF, '0, "R9");
    for (int i = 0; i < 4; i++) step(1, 0, 4'hF, mk(t++), "R9");
    repeat (4) step(0, 0, 4'hF, '0, "R10");
    chk(exp_q.size() == 0, "R4 drain", 128'(exp_q.size()), 128'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule